// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Bus Front End

This block is the digital side of a two-channel, 12-bit converter that hangs on a parallel processor bus. Each channel holds two codes: a staging code written from the bus, and an output code that feeds the converter. A host first loads the staging codes one channel at a time. It then moves both into the output stage with a single shared update, so the two analog outputs change at the same instant.

All bus controls are active low and are sampled on the rising clock edge. Each operation is edge-detected: it takes effect once, on the first cycle its combined condition holds. A width-select pin chooses between two write formats. In full-width mode all twelve bits are stored. In byte mode only the low nibble is written, and it is taken from the top four data lines, so an 8-bit bus wired to the upper lines can complete a value. A clear, qualified by the same update strobe as the transfer, forces both output codes to midscale (12'h800), which is the code for zero volts on a bipolar output.

Top module: `dual_dac_front`

## Requirements
- R1: A staging write happens only on a clock edge where both `csN` and `wr1N` are low; either one high blocks it.
- R2: `chanSel` = 0 writes channel 0's staging code and `chanSel` = 1 writes channel 1's; the other channel's staging code is unchanged.
- R3: With `fullWidth` = 1, all twelve bits of `dataIn` (bit 11 is the MSB) are stored in the selected staging code.
- R4: With `fullWidth` = 0, staging bits 3..0 take `dataIn[11:8]` and staging bits 11..4 keep their value.
- R5: With `wr2N` and `xferN` both low, both staging codes are copied into both output codes at the same edge.
- R6: With `wr2N` and `clrN` both low, both output codes become 12'h800 on the next edge, and the staging codes are unchanged.
- R7: If clear and transfer are qualified by `wr2N` on the same edge, the clear wins: both outputs become 12'h800 and no transfer happens, even after the clear is released.
- R8: Each operation acts once, on the first edge its condition is true. Holding the condition acts again only after it has gone false.
- R9: After reset, both staging codes and both output codes are 12'h800.
- R10: The output codes change only on a transfer or a clear. A staging write never changes them directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| wr1N | input | 1 | Staging write strobe, active low |
| wr2N | input | 1 | Update strobe, active low |
| xferN | input | 1 | Transfer qualifier, active low |
| clrN | input | 1 | Clear qualifier, active low |
| chanSel | input | 1 | Target channel for staging writes |
| fullWidth | input | 1 | 1 = 12-bit write, 0 = low-nibble byte write |
| dataIn | input | 12 | Data bus |
| dacCode0 | output | 12 | Output code, channel 0 |
| dacCode1 | output | 12 | Output code, channel 1 |

## Verification
The assertions assume that every control pin holds a defined level on each rising edge. They also assume that `dataIn`, `chanSel` and `fullWidth` are stable on the edge where a write condition first becomes true. The bench meets both assumptions by changing inputs only on falling edges. Every operation is a two-phase pulse: assert on one falling edge, release on the next. The only exceptions are the deliberate hold tests, which check that an operation acts once.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int DATA_W = 12;
  localparam int NIB_W  = 4;

  typedef struct packed {
    logic load;   // one-cycle staging write
    logic chan;   // target channel for load
    logic full;   // full-width write when set
    logic xfer;   // one-cycle simultaneous update
    logic clr;    // one-cycle midscale clear
  } ctrlStb_t;
endpackage

// File: rtl/dacif_ctrl.sv
module dacif_ctrl
  import dacif_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     csN,
  input  logic     wr1N,
  input  logic     wr2N,
  input  logic     xferN,
  input  logic     clrN,
  input  logic     chanSel,
  input  logic     fullWidth,
  output ctrlStb_t stb
);
  logic loadCond, xferCond, clrCond;
  logic loadPrev, xferPrev, clrPrev;

  assign loadCond = !csN && !wr1N;
  assign xferCond = !wr2N && !xferN;
  assign clrCond  = !wr2N && !clrN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadPrev <= 1'b0;
      xferPrev <= 1'b0;
      clrPrev  <= 1'b0;
    end else begin
      loadPrev <= loadCond;
      xferPrev <= xferCond;
      clrPrev  <= clrCond;
    end
  end

  always_comb begin
    stb.load = loadCond && !loadPrev;
    stb.chan = chanSel;
    stb.full = fullWidth;
    stb.clr  = clrCond && !clrPrev;
    // a clear that is being qualified suppresses any transfer edge
    stb.xfer = xferCond && !xferPrev && !clrCond;
  end

  AST_LOAD_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> !stb.load); // R8
  AST_XFER_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    stb.xfer |=> !stb.xfer); // R8
  AST_CLR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> !stb.clr); // R8
endmodule

// File: rtl/dacif_datapath.sv
module dacif_datapath
  import dacif_pkg::*;
#(
  parameter int W    = DATA_W,
  parameter int LOWW = NIB_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStb_t     stb,
  input  logic [W-1:0] dataIn,
  output logic [W-1:0] dacOut [2]
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] stageReg [2];
  logic [W-1:0] dacReg   [2];

  for (genvar g = 0; g < 2; g++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageReg[g] <= MID;
      end else if (stb.load && (stb.chan == 1'(g))) begin
        if (stb.full)
          stageReg[g] <= dataIn;
        else
          stageReg[g][LOWW-1:0] <= dataIn[W-1 -: LOWW];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         dacReg[g] <= MID;
      else if (stb.clr)  dacReg[g] <= MID;
      else if (stb.xfer) dacReg[g] <= stageReg[g];
    end

    assign dacOut[g] = dacReg[g];

    AST_BYTE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      (stb.load && !stb.full && stb.chan == 1'(g)) |=>
        stageReg[g][W-1:LOWW] == $past(stageReg[g][W-1:LOWW])); // R4
    AST_XFER_COPIES: assert property (@(posedge clk) disable iff (!rstN)
      (stb.xfer && !stb.clr) |=> dacReg[g] == $past(stageReg[g])); // R5
    AST_CLR_MIDSCALE: assert property (@(posedge clk) disable iff (!rstN)
      stb.clr |=> dacReg[g] == MID); // R6
    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (!stb.clr && !stb.xfer) |=> $stable(dacReg[g])); // R10
    AST_OTHER_CHAN_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
      (stb.load && stb.chan != 1'(g)) |=> $stable(stageReg[g])); // R2
  end
endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front
  import dacif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wr1N,
  input  logic              wr2N,
  input  logic              xferN,
  input  logic              clrN,
  input  logic              chanSel,
  input  logic              fullWidth,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dacCode0,
  output logic [DATA_W-1:0] dacCode1
);
  ctrlStb_t    stb;
  logic [DATA_W-1:0] dacOut [2];

  dacif_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .wr1N(wr1N), .wr2N(wr2N),
    .xferN(xferN), .clrN(clrN), .chanSel(chanSel), .fullWidth(fullWidth),
    .stb(stb)
  );

  dacif_datapath #(.W(DATA_W), .LOWW(NIB_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .dataIn(dataIn), .dacOut(dacOut)
  );

  assign dacCode0 = dacOut[0];
  assign dacCode1 = dacOut[1];

  AST_RESET_MID: assert property (@(posedge clk)
    $rose(rstN) |-> (dacCode0 == 12'h800 && dacCode1 == 12'h800)); // R9
endmodule

// File: tb/dual_dac_front_tb_top.sv
module dual_dac_front_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, wr1N = 1'b1, wr2N = 1'b1, xferN = 1'b1, clrN = 1'b1;
  logic chanSel = 1'b0, fullWidth = 1'b1;
  logic [11:0] dataIn = '0;
  logic [11:0] dacCode0, dacCode1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [11:0] stM [2];
  logic [11:0] dacM [2];

  always #10 clk = ~clk;

  dual_dac_front dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .wr1N(wr1N), .wr2N(wr2N),
    .xferN(xferN), .clrN(clrN), .chanSel(chanSel), .fullWidth(fullWidth),
    .dataIn(dataIn), .dacCode0(dacCode0), .dacCode1(dacCode1)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkOut(input string req);
    @(negedge clk);
    chk(req, dacCode0, dacM[0]);
    chk(req, dacCode1, dacM[1]);
  endtask

  task automatic busWrite(input logic ch, input logic full, input logic [11:0] d);
    @(negedge clk);
    chanSel = ch; fullWidth = full; dataIn = d; csN = 0; wr1N = 0;
    @(negedge clk);
    csN = 1; wr1N = 1;
    if (full) stM[ch] = d;
    else      stM[ch] = {stM[ch][11:4], d[11:8]};
  endtask

  task automatic doXfer();
    @(negedge clk);
    wr2N = 0; xferN = 0;
    @(negedge clk);
    wr2N = 1; xferN = 1;
    dacM[0] = stM[0]; dacM[1] = stM[1];
  endtask

  task automatic doClr();
    @(negedge clk);
    wr2N = 0; clrN = 0;
    @(negedge clk);
    wr2N = 1; clrN = 1;
    dacM[0] = 12'h800; dacM[1] = 12'h800;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    stM[0] = 12'h800; stM[1] = 12'h800;
    dacM[0] = 12'h800; dacM[1] = 12'h800;
    repeat (3) @(negedge clk);
    rstN = 1;
    chkOut("R9 reset output");
    doXfer();
    chkOut("R9 reset staging");

    // sweep: full write, byte write, transfer, per channel
    for (int ch = 0; ch < 2; ch++) begin
      for (int v = 0; v < 4096; v += 13) begin
        busWrite(ch[0], 1'b1, 12'(v));
        chkOut("R10 write leaves outputs");
        busWrite(ch[0], 1'b0, 12'((v * 7 + 3) % 4096));
        doXfer();
        chkOut(ch == 0 ? "R3 R4 R5 R2 chan0" : "R3 R4 R5 R2 chan1");
      end
    end

    // R1: single strobe without the other does nothing
    busWrite(1'b0, 1'b1, 12'h123);
    busWrite(1'b1, 1'b1, 12'h456);
    @(negedge clk); chanSel = 0; fullWidth = 1; dataIn = 12'hFFF; csN = 1; wr1N = 0;
    @(negedge clk); wr1N = 1; csN = 0;
    @(negedge clk); csN = 1;
    doXfer();
    chkOut("R1 partial strobe ignored");

    // update strobe alone does nothing
    busWrite(1'b0, 1'b1, 12'h0AA);
    @(negedge clk); wr2N = 0;
    @(negedge clk); wr2N = 1;
    chkOut("R10 wr2 alone");

    // R6: clear, staging unchanged
    doXfer();
    busWrite(1'b0, 1'b1, 12'h3C5);
    busWrite(1'b1, 1'b1, 12'hE19);
    doClr();
    chkOut("R6 clear midscale");
    doXfer();
    chkOut("R6 staging kept");

    // R7: clear and transfer together
    busWrite(1'b0, 1'b1, 12'h777);
    @(negedge clk); wr2N = 0; xferN = 0; clrN = 0;
    @(negedge clk); clrN = 1;
    dacM[0] = 12'h800; dacM[1] = 12'h800;
    @(negedge clk); wr2N = 1; xferN = 1;
    chkOut("R7 clear wins");
    doXfer();
    chkOut("R7 later transfer");

    // R8: held write stores only first value
    @(negedge clk); chanSel = 1; fullWidth = 1; dataIn = 12'h5A5; csN = 0; wr1N = 0;
    @(negedge clk); dataIn = 12'hA5A;
    @(negedge clk); csN = 1; wr1N = 1;
    stM[1] = 12'h5A5;
    doXfer();
    chkOut("R8 held write once");

    // R8: held transfer does not repeat
    @(negedge clk); wr2N = 0; xferN = 0;
    dacM[0] = stM[0]; dacM[1] = stM[1];
    busWrite(1'b0, 1'b1, 12'h0F0);
    chkOut("R8 held transfer once");
    @(negedge clk); wr2N = 1; xferN = 1;
    chkOut("R8 held transfer released");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule